// File: doc/BRIEF.md
# Two-Level Carry Lookahead Adder

A combinational binary adder that takes two unsigned operands and a carry-in and returns their sum and the carry out of the top bit. The operand is split into equal groups of bits. Each group forms per-bit generate (both bits set) and propagate (exactly one bit set) terms. It resolves its internal carries as flat sums of products over those terms and its own incoming carry. It also reports whether the group as a whole generates or propagates a carry.

A second tier takes the group-level generate and propagate signals together with the adder carry-in. By default it computes every group's incoming carry and the final carry-out with the same flat lookahead. No carry then ripples from one group to the next. A parameter can swap that second tier for a simple chain, in which each group's carry feeds the next group. This trades speed for less logic while giving the same arithmetic result. The default build is 16 bits made of four 4-bit groups.

Top module: `cla16_adder`

## Requirements
- R1: `sum_out` equals the low DATA_W bits of the unsigned value `a_in + b_in + carry_in`.
- R2: `carry_out` equals bit DATA_W (the bit above the sum) of `a_in + b_in + carry_in`.
- R3: The carry entering group k (bit position k*GROUP_W) equals the carry out of adding the lower k*GROUP_W bits of both operands plus `carry_in`; for example 0x000F + 0x0001 gives 0x0010.
- R4: A group in which every bit pair propagates passes its incoming carry straight through. 0xFFFF + 0x0000 gives sum 0x0000 and carry-out 1 when `carry_in` is 1, and sum 0xFFFF and carry-out 0 when it is 0.
- R5: A group that generates a carry on its own sends a carry out whatever its incoming carry. 0x8000 + 0x8000 gives carry-out 1 with sum 0x0000 when `carry_in` is 0, and with sum 0x0001 when `carry_in` is 1.
- R6: With both operands zero, `carry_out` is 0 and `sum_out` equals `carry_in`.
- R7: With SCHEME set to the ripple variant, the outputs are identical to the lookahead variant for every input.
- R8: GROUP_W and NUM_GROUPS set the structure. Any combination gives a correct DATA_W = GROUP_W*NUM_GROUPS bit adder, including 2-bit groups with three groups.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | DATA_W | First operand (unsigned) |
| b_in | input | DATA_W | Second operand (unsigned) |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | DATA_W | Sum bits |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
The bench builds three copies of the adder. The first is the default 16-bit lookahead build, driven with full carry-chain cases and random operands. The second is the same width with SCHEME set to the ripple variant; it receives identical inputs and is compared against the same expected values, which reaches R7. The third has GROUP_W=2 and NUM_GROUPS=3. Its 6-bit range is small enough to cover every operand pair under both carry-in values, so every boundary and group-carry pattern of that shape is exercised.

// File: rtl/cla_pkg.sv
// Package: shared defaults and the carry scheme selector for the
// grouped lookahead adder. Assumes nothing beyond integer arithmetic.
package cla_pkg;

    // Default bits per group and groups per adder.
    localparam int GROUP_W_DEF    = 4;
    localparam int NUM_GROUPS_DEF = 4;

    // How the carries between groups are formed.
    typedef enum logic {
        SCHEME_LOOKAHEAD = 1'b0,  // second lookahead tier over group G/P
        SCHEME_RIPPLE    = 1'b1   // group carry chained group to group
    } carry_scheme_e;

endpackage : cla_pkg

// File: rtl/cla_bit_pg.sv
// Module: cla_bit_pg
// Forms the generate and propagate terms of a single bit position.
// Assumes unsigned operand bits; purely combinational.
module cla_bit_pg (
    input  logic a_bit,
    input  logic b_bit,
    output logic gen,
    output logic prop
);

    // Generate when both bits set, propagate when exactly one is set.
    always_comb begin
        gen  = a_bit & b_bit;
        prop = a_bit ^ b_bit;
    end

endmodule : cla_bit_pg

// File: rtl/cla_lookahead_unit.sv
// Module: cla_lookahead_unit
// Flat two-level lookahead over W positions. Given per-position
// generate/propagate terms and a carry into position 0, produces the
// carry into every position as an OR of AND terms (no chain), plus the
// block-level generate and propagate. Used both inside each group and
// as the second tier across groups. Assumes W >= 1.
module cla_lookahead_unit #(
    parameter int W = 4
) (
    input  logic [W-1:0] gen,
    input  logic [W-1:0] prop,
    input  logic         cin,
    output logic [W-1:0] carry_into,
    output logic         blk_gen,
    output logic         blk_prop
);

    // Carry into position j: any lower generate whose path up to j
    // propagates, or the incoming carry propagated through all of 0..j-1.
    always_comb begin
        for (int j = 0; j < W; j++) begin
            logic acc;
            logic chain;
            acc   = 1'b0;
            chain = cin;
            for (int k = 0; k < j; k++) begin
                logic term;
                term = gen[k];
                for (int m = k + 1; m < j; m++) begin
                    term = term & prop[m];
                end
                acc   = acc | term;
                chain = chain & prop[k];
            end
            carry_into[j] = acc | chain;
        end
    end

    // Block generate: a carry leaves the top with no carry entering.
    always_comb begin
        blk_gen = 1'b0;
        for (int k = 0; k < W; k++) begin
            logic term;
            term = gen[k];
            for (int m = k + 1; m < W; m++) begin
                term = term & prop[m];
            end
            blk_gen = blk_gen | term;
        end
    end

    // Block propagate: every position passes a carry.
    always_comb begin
        blk_prop = &prop;
    end

endmodule : cla_lookahead_unit

// File: rtl/cla_group.sv
// Module: cla_group
// One W-bit slice of the adder: per-bit G/P cells, internal lookahead,
// sum bits, and group-level G/P for the tier above. The carry into the
// group arrives from outside; the group's own carry-out is not formed
// here (the tier above derives it from grp_gen/grp_prop).
module cla_group #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         grp_gen,
    output logic         grp_prop
);

    logic [W-1:0] bit_gen;
    logic [W-1:0] bit_prop;
    logic [W-1:0] bit_cin;

    // One generate/propagate cell per bit.
    for (genvar i = 0; i < W; i++) begin : g_bit
        cla_bit_pg u_pg (
            .a_bit (a_in[i]),
            .b_bit (b_in[i]),
            .gen   (bit_gen[i]),
            .prop  (bit_prop[i])
        );
    end

    cla_lookahead_unit #(.W(W)) u_look (
        .gen        (bit_gen),
        .prop       (bit_prop),
        .cin        (cin),
        .carry_into (bit_cin),
        .blk_gen    (grp_gen),
        .blk_prop   (grp_prop)
    );

    // Sum bit is propagate XOR carry into that bit.
    always_comb begin
        sum = bit_prop ^ bit_cin;
    end

endmodule : cla_group

// File: rtl/cla_group_carry.sv
// Module: cla_group_carry
// Second tier: turns the group G/P signals and the adder carry-in into
// the carry entering each group and the final carry-out. SCHEME picks
// a flat lookahead across groups or a group-to-group chain.
module cla_group_carry #(
    parameter int                    N      = 4,
    parameter cla_pkg::carry_scheme_e SCHEME = cla_pkg::SCHEME_LOOKAHEAD
) (
    input  logic [N-1:0] grp_gen,
    input  logic [N-1:0] grp_prop,
    input  logic         cin,
    output logic [N-1:0] grp_cin,
    output logic         cout
);

    if (SCHEME == cla_pkg::SCHEME_LOOKAHEAD) begin : g_look
        logic all_gen;
        logic all_prop;

        cla_lookahead_unit #(.W(N)) u_tier (
            .gen        (grp_gen),
            .prop       (grp_prop),
            .cin        (cin),
            .carry_into (grp_cin),
            .blk_gen    (all_gen),
            .blk_prop   (all_prop)
        );

        // Final carry from the whole-word generate/propagate.
        always_comb begin
            cout = all_gen | (all_prop & cin);
        end
    end else begin : g_ripple
        logic [N:0] chain;

        // Each group's carry-out feeds the next group in turn.
        always_comb begin
            chain[0] = cin;
            for (int k = 0; k < N; k++) begin
                chain[k+1] = grp_gen[k] | (grp_prop[k] & chain[k]);
            end
            grp_cin = chain[N-1:0];
            cout    = chain[N];
        end
    end

endmodule : cla_group_carry

// File: rtl/cla16_adder.sv
// Module: cla16_adder
// Top of the grouped carry lookahead adder: NUM_GROUPS slices of
// GROUP_W bits, tied together by the second carry tier. Purely
// combinational; outputs follow inputs with no clock or state.
module cla16_adder #(
    parameter int                     GROUP_W    = cla_pkg::GROUP_W_DEF,
    parameter int                     NUM_GROUPS = cla_pkg::NUM_GROUPS_DEF,
    parameter cla_pkg::carry_scheme_e SCHEME     = cla_pkg::SCHEME_LOOKAHEAD,
    localparam int                    DATA_W     = GROUP_W * NUM_GROUPS
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic              carry_in,
    output logic [DATA_W-1:0] sum_out,
    output logic              carry_out
);

    logic [NUM_GROUPS-1:0] grp_gen;
    logic [NUM_GROUPS-1:0] grp_prop;
    logic [NUM_GROUPS-1:0] grp_cin;

    // Slice the operands into groups.
    for (genvar gi = 0; gi < NUM_GROUPS; gi++) begin : g_grp
        cla_group #(.W(GROUP_W)) u_grp (
            .a_in     (a_in[gi*GROUP_W +: GROUP_W]),
            .b_in     (b_in[gi*GROUP_W +: GROUP_W]),
            .cin      (grp_cin[gi]),
            .sum      (sum_out[gi*GROUP_W +: GROUP_W]),
            .grp_gen  (grp_gen[gi]),
            .grp_prop (grp_prop[gi])
        );
    end

    cla_group_carry #(.N(NUM_GROUPS), .SCHEME(SCHEME)) u_tier2 (
        .grp_gen  (grp_gen),
        .grp_prop (grp_prop),
        .cin      (carry_in),
        .grp_cin  (grp_cin),
        .cout     (carry_out)
    );

endmodule : cla16_adder

// File: rtl/cla16_adder_checker.sv
// Module: cla16_adder_checker
// Assertion checker bound into cla16_adder. Compares the ports and the
// group-level carries against plain arithmetic on the operands.
module cla16_adder_checker #(
    parameter int  GROUP_W    = 4,
    parameter int  NUM_GROUPS = 4,
    localparam int DATA_W     = GROUP_W * NUM_GROUPS
) (
    input logic [DATA_W-1:0]     a_in,
    input logic [DATA_W-1:0]     b_in,
    input logic                  carry_in,
    input logic [DATA_W-1:0]     sum_out,
    input logic                  carry_out,
    input logic [NUM_GROUPS-1:0] grp_gen,
    input logic [NUM_GROUPS-1:0] grp_prop,
    input logic [NUM_GROUPS-1:0] grp_cin
);

    logic [DATA_W:0]       total;
    logic [NUM_GROUPS-1:0] ref_cin;
    logic [NUM_GROUPS-1:0] carry_after;

    // Arithmetic reference for the whole word.
    always_comb begin
        total = {1'b0, a_in} + {1'b0, b_in} + {{DATA_W{1'b0}}, carry_in};
    end

    // Reference carry into each group from the lower slice alone.
    for (genvar k = 0; k < NUM_GROUPS; k++) begin : g_ref
        if (k == 0) begin : g_first
            always_comb ref_cin[k] = carry_in;
        end else begin : g_rest
            localparam int LO = k * GROUP_W;
            localparam int PW = LO + 1;
            logic [LO:0] part;
            always_comb begin
                part = PW'(a_in[LO-1:0]) + PW'(b_in[LO-1:0]) + PW'(carry_in);
                ref_cin[k] = part[LO];
            end
        end
    end

    // Carry leaving each group, as seen by its neighbour or the port.
    always_comb begin
        for (int k = 0; k < NUM_GROUPS; k++) begin
            carry_after[k] = (k == NUM_GROUPS - 1) ? carry_out : grp_cin[k+1];
        end
    end

    // Immediate checks on the settled combinational values.
    always_comb begin
        assert_sum_R1: assert (sum_out == total[DATA_W-1:0])
            else $error("R1 sum %h expected %h", sum_out, total[DATA_W-1:0]);
        assert_carry_out_R2: assert (carry_out == total[DATA_W])
            else $error("R2 carry_out %b expected %b", carry_out, total[DATA_W]);
        assert_zero_kill_R6: assert (!((a_in == '0) && (b_in == '0)) || !carry_out)
            else $error("R6 carry_out set with zero operands");
        for (int k = 0; k < NUM_GROUPS; k++) begin
            assert_group_cin_R3: assert (grp_cin[k] == ref_cin[k])
                else $error("R3 group %0d carry %b expected %b", k, grp_cin[k], ref_cin[k]);
            assert_group_prop_R4: assert (!grp_prop[k] || (carry_after[k] == grp_cin[k]))
                else $error("R4 group %0d did not pass its carry", k);
            assert_group_gen_R5: assert (!grp_gen[k] || carry_after[k])
                else $error("R5 group %0d generate lost", k);
        end
    end

endmodule : cla16_adder_checker

bind cla16_adder cla16_adder_checker #(
    .GROUP_W    (GROUP_W),
    .NUM_GROUPS (NUM_GROUPS)
) u_checker (
    .a_in      (a_in),
    .b_in      (b_in),
    .carry_in  (carry_in),
    .sum_out   (sum_out),
    .carry_out (carry_out),
    .grp_gen   (grp_gen),
    .grp_prop  (grp_prop),
    .grp_cin   (grp_cin)
);

// File: tb/cla16_adder_tb.sv
// Bench: scoreboard for the grouped lookahead adder. A driver task
// applies operands on the rising edge and queues the expected result;
// a monitor on the falling edge pops and compares both 16-bit builds.
// A third, 6-bit build is swept over every input.
module cla16_adder_tb;

    localparam int DW = 16;
    localparam int SW = 6;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    logic [DW-1:0] a_r = '0;
    logic [DW-1:0] b_r = '0;
    logic          c_r = 1'b0;
    logic [DW-1:0] sum_la, sum_rp;
    logic          cout_la, cout_rp;

    logic [SW-1:0] sa = '0;
    logic [SW-1:0] sb = '0;
    logic          sc = 1'b0;
    logic [SW-1:0] ssum;
    logic          scout;

    cla16_adder u_dut (
        .a_in (a_r), .b_in (b_r), .carry_in (c_r),
        .sum_out (sum_la), .carry_out (cout_la)
    );

    cla16_adder #(.SCHEME(cla_pkg::SCHEME_RIPPLE)) u_dut_ripple (
        .a_in (a_r), .b_in (b_r), .carry_in (c_r),
        .sum_out (sum_rp), .carry_out (cout_rp)
    );

    cla16_adder #(.GROUP_W(2), .NUM_GROUPS(3)) u_dut_small (
        .a_in (sa), .b_in (sb), .carry_in (sc),
        .sum_out (ssum), .carry_out (scout)
    );

    typedef struct {
        logic [DW-1:0] exp_sum;
        logic          exp_cout;
        string         req;
    } item_t;

    item_t sb_q[$];

    // Count one comparison and report a mismatch.
    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Apply one operand pair and queue its expected result.
    task automatic drive(input logic [DW-1:0] a, input logic [DW-1:0] b,
                         input logic c, input string req);
        logic [DW:0] full;
        item_t it;
        @(posedge clk);
        a_r  <= a;
        b_r  <= b;
        c_r  <= c;
        full = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, c};
        it.exp_sum  = full[DW-1:0];
        it.exp_cout = full[DW];
        it.req      = req;
        sb_q.push_back(it);
    endtask

    // Monitor: compare both 16-bit builds against the queued result.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check(it.req, "sum", 32'(sum_la), 32'(it.exp_sum));
            check(it.req, "carry_out", 32'(cout_la), 32'(it.exp_cout));
            check("R7", "ripple sum", 32'(sum_rp), 32'(it.exp_sum));
            check("R7", "ripple carry_out", 32'(cout_rp), 32'(it.exp_cout));
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R6: both operands zero, with and without carry-in.
        drive(16'h0000, 16'h0000, 1'b0, "R6");
        drive(16'h0000, 16'h0000, 1'b1, "R6");
        // R3: carry generated in a lower group enters the next one.
        drive(16'h000F, 16'h0001, 1'b0, "R3");
        drive(16'h00FF, 16'h0000, 1'b1, "R3");
        drive(16'h0FFF, 16'h0001, 1'b0, "R3");
        // R4: full propagate across every group.
        drive(16'hFFFF, 16'h0000, 1'b1, "R4");
        drive(16'hFFFF, 16'h0000, 1'b0, "R4");
        drive(16'hAAAA, 16'h5555, 1'b1, "R4");
        drive(16'hFFFF, 16'h0001, 1'b0, "R4");
        // R5: top group generates regardless of carry-in.
        drive(16'h8000, 16'h8000, 1'b0, "R5");
        drive(16'h8000, 16'h8000, 1'b1, "R5");
        drive(16'hFFFF, 16'hFFFF, 1'b1, "R5");
        // R1/R2: random operands.
        for (int i = 0; i < 3000; i++) begin
            drive(16'($urandom), 16'($urandom), 1'($urandom), "R1");
        end
        @(posedge clk);
        @(posedge clk);

        // R8: exhaustive sweep of the 2x3-group build.
        for (int c = 0; c < 2; c++) begin
            for (int a = 0; a < (1 << SW); a++) begin
                for (int b = 0; b < (1 << SW); b++) begin
                    logic [SW:0] full;
                    @(posedge clk);
                    sa <= SW'(a);
                    sb <= SW'(b);
                    sc <= 1'(c);
                    full = (SW+1)'(a) + (SW+1)'(b) + (SW+1)'(c);
                    @(negedge clk);
                    check("R8", "small sum", 32'(ssum), 32'(full[SW-1:0]));
                    check("R8", "small carry_out", 32'(scout), 32'(full[SW]));
                end
            end
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule : cla16_adder_tb